// File: doc/BRIEF.md
# Reflected Byte-Wise CRC-32 Engine

This block keeps a running 32-bit cyclic redundancy check over a byte stream. It uses the common 32-bit generator polynomial in its bit-reversed form. The register holds the x^31 coefficient in bit 0 and shifts toward bit 0. Each accepted byte advances the register by one full byte step in a single clock. The step is a table lookup: a 256-entry feedback table is computed from the polynomial at elaboration.

A short strobe re-seeds the register for a new message. A readout request takes a snapshot of the finished checksum, which is the register inverted. The snapshot leaves on a byte port over four consecutive cycles, least significant byte first. An LSB-first serial link that sends those bytes in turn puts the highest-order coefficient on the wire first, with no bit reordering. A receiver runs the same engine over the incoming bytes.

Top module: `crc32r_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `crc_o` reads 0xFFFFFFFF and `rd_vld_o` is 0.
- R2: When `init_i` is high at a clock edge, `crc_o` reads 0xFFFFFFFF after that edge. This holds even if a data byte is valid in the same cycle.
- R3: An accepted byte d changes the register to the result of eight single-bit steps taken on d from bit 0 to bit 7. Each step computes f = crc[0] XOR d[i], shifts crc right by one with a zero fill, and then XORs 0xEDB88320 into crc when f is 1.
- R4: With `init_i` and `data_vld_i` both low, `crc_o` does not change, whatever value `data_i` carries.
- R5: After init, feeding the ASCII bytes "123456789" gives `crc_o` = 0x340BC6D9. The readout then gives 0xCBF43926 as the bytes 0x26, 0x39, 0xF4, 0xCB.
- R6: A readout request while idle makes `rd_vld_o` high for exactly the next four cycles. `rd_byte_o` then carries bytes 0 to 3 of (`crc_o` XOR 0xFFFFFFFF), in that order, using the register value at the request edge.
- R7: A data byte that is valid in the request cycle or in any of the four readout cycles is ignored. A readout request made during a readout is also ignored.
- R8: A readout does not change the register. Bytes accepted after a readout continue the CRC from the value the register held before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Re-seed the register with all ones |
| data_i | input | 8 | Data byte |
| data_vld_i | input | 1 | Data byte is valid this cycle |
| rd_req_i | input | 1 | Start a four-byte readout of the checksum |
| crc_o | output | 32 | Live CRC register |
| rd_byte_o | output | 8 | Readout byte, low byte first |
| rd_vld_o | output | 1 | `rd_byte_o` is valid |

## Verification
The bench builds the engine with its default parameters. These are the reflected standard polynomial, an all-ones seed and an all-ones output inversion, so the published check value for "123456789" can be tested directly. A bit-at-a-time model written in the bench checks every lookup-based update under random bytes and random idle gaps. The bench also drives junk bytes and repeated requests into the readout window. This shows that the snapshot, the byte order and the frozen register behave as specified.

// File: rtl/crc32r_pkg.sv
package crc32r_pkg;

    localparam int unsigned CRC_W  = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned TBL_N  = 1 << BYTE_W;
    localparam int unsigned NBYTES = CRC_W / BYTE_W;
    localparam int unsigned IDX_W  = $clog2(NBYTES);

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  bidx_t;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_SEND = 1'b1
    } rd_state_e;

    typedef struct packed {
        rd_state_e st;
        bidx_t     idx;
        crc_t      snap;
    } rd_ctx_t;

    // eight right shifts with conditional feedback, starting from the index
    function automatic crc_t fb_term(input crc_t poly, input byte_t idx);
        crc_t r;
        r = crc_t'(idx);
        for (int k = 0; k < BYTE_W; k++) begin
            if (r[0]) r = (r >> 1) ^ poly;
            else      r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/crc32r_table.sv
module crc32r_table
    import crc32r_pkg::*;
#(
    parameter crc_t POLY = 32'hEDB88320
) (
    input  byte_t idx,
    output crc_t  term
);

    crc_t tbl [TBL_N];

    for (genvar i = 0; i < TBL_N; i++) begin : g_ent
        assign tbl[i] = fb_term(POLY, byte_t'(i));
    end

    assign term = tbl[idx];

endmodule

// File: rtl/crc32r_step.sv
module crc32r_step
    import crc32r_pkg::*;
#(
    parameter crc_t POLY = 32'hEDB88320
) (
    input  crc_t  cur,
    input  byte_t data,
    output crc_t  nxt
);

    byte_t lookup;
    crc_t  term;

    assign lookup = cur[BYTE_W-1:0] ^ data;

    crc32r_table #(.POLY(POLY)) i_table (
        .idx  (lookup),
        .term (term)
    );

    assign nxt = (cur >> BYTE_W) ^ term;

endmodule

// File: rtl/crc32r_readout.sv
module crc32r_readout
    import crc32r_pkg::*;
#(
    parameter crc_t XOROUT = 32'hFFFFFFFF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  crc_t  value,
    output logic  busy,
    output logic  byte_vld,
    output byte_t byte_o
);

    rd_ctx_t ctx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.st   <= RD_IDLE;
            ctx.idx  <= '0;
            ctx.snap <= '0;
        end else begin
            unique case (ctx.st)
                RD_IDLE: begin
                    if (start) begin
                        ctx.st   <= RD_SEND;
                        ctx.idx  <= '0;
                        ctx.snap <= value ^ XOROUT;
                    end
                end
                RD_SEND: begin
                    if (ctx.idx == bidx_t'(NBYTES - 1)) begin
                        ctx.st <= RD_IDLE;
                    end else begin
                        ctx.idx <= ctx.idx + 1'b1;
                    end
                end
                default: ctx.st <= RD_IDLE;
            endcase
        end
    end

    assign busy     = (ctx.st == RD_SEND);
    assign byte_vld = busy;
    assign byte_o   = ctx.snap[ctx.idx * BYTE_W +: BYTE_W];

endmodule

// File: rtl/crc32r_engine.sv
module crc32r_engine
    import crc32r_pkg::*;
#(
    parameter crc_t POLY   = 32'hEDB88320,
    parameter crc_t INIT   = 32'hFFFFFFFF,
    parameter crc_t XOROUT = 32'hFFFFFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init_i,
    input  logic [7:0]  data_i,
    input  logic        data_vld_i,
    input  logic        rd_req_i,
    output logic [31:0] crc_o,
    output logic [7:0]  rd_byte_o,
    output logic        rd_vld_o
);

    crc_t crc_q;
    crc_t crc_nxt;
    logic rd_busy;
    logic blocked;
    logic take;

    crc32r_step #(.POLY(POLY)) i_step (
        .cur  (crc_q),
        .data (data_i),
        .nxt  (crc_nxt)
    );

    assign blocked = rd_busy | rd_req_i;
    assign take    = data_vld_i & ~blocked;

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            crc_q <= INIT;
        end else if (take) begin
            crc_q <= crc_nxt;
        end
    end

    crc32r_readout #(.XOROUT(XOROUT)) i_readout (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_req_i),
        .value    (crc_q),
        .busy     (rd_busy),
        .byte_vld (rd_vld_o),
        .byte_o   (rd_byte_o)
    );

    assign crc_o = crc_q;

endmodule

// File: rtl/crc32r_checker.sv
module crc32r_checker #(
    parameter int unsigned NBYTES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        init_i,
    input logic        data_vld_i,
    input logic        rd_req_i,
    input logic [31:0] crc_o,
    input logic        rd_vld_o
);

    logic [3:0] run;

    always_ff @(posedge clk) begin
        if (rst)           run <= '0;
        else if (rd_vld_o) run <= run + 1'b1;
        else               run <= '0;
    end

    assert_reset_seed_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (crc_o == 32'hFFFFFFFF && !rd_vld_o));

    assert_init_load_R2: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (crc_o == 32'hFFFFFFFF));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!init_i && !data_vld_i) |=> $stable(crc_o));

    assert_burst_len_R6: assert property (@(posedge clk) disable iff (rst)
        rd_vld_o |-> (32'(run) < NBYTES));

    assert_burst_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_vld_o) |-> $past(rd_req_i));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_vld_o && !init_i) |=> $stable(crc_o));

endmodule

bind crc32r_engine crc32r_checker #(.NBYTES(4)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_i),
    .data_vld_i (data_vld_i),
    .rd_req_i   (rd_req_i),
    .crc_o      (crc_o),
    .rd_vld_o   (rd_vld_o)
);

// File: tb/test_crc32r_engine.sv
module test_crc32r_engine;

    localparam logic [31:0] P = 32'hEDB88320;

    logic        clk = 1'b0;
    logic        rst;
    logic        init_i;
    logic [7:0]  data_i;
    logic        data_vld_i;
    logic        rd_req_i;
    logic [31:0] crc_o;
    logic [7:0]  rd_byte_o;
    logic        rd_vld_o;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic [31:0] model;

    always #10 clk = ~clk;

    crc32r_engine i_crc32r_engine (
        .clk        (clk),
        .rst        (rst),
        .init_i     (init_i),
        .data_i     (data_i),
        .data_vld_i (data_vld_i),
        .rd_req_i   (rd_req_i),
        .crc_o      (crc_o),
        .rd_byte_o  (rd_byte_o),
        .rd_vld_o   (rd_vld_o)
    );

    function automatic logic [31:0] bit_ref(input logic [31:0] c, input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            logic f;
            f = c[0] ^ d[i];
            c = c >> 1;
            if (f) c = c ^ P;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d);
        data_i = d; data_vld_i = 1'b1;
        @(negedge clk);
        data_vld_i = 1'b0;
        model = bit_ref(model, d);
    endtask

    task automatic do_init();
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
        model = 32'hFFFFFFFF;
    endtask

    // readout with optional junk data and held request during the window
    task automatic readout(input bit junk);
        logic [31:0] res;
        res = ~model;
        rd_req_i = 1'b1;
        data_vld_i = junk;
        data_i = 8'($urandom);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 vld", 32'(rd_vld_o), 32'd1);
            check("R6 byte", 32'(rd_byte_o), (res >> (8 * k)) & 32'hFF);
            data_i = 8'($urandom);
        end
        @(negedge clk);
        check("R6 end", 32'(rd_vld_o), 32'd0);
        rd_req_i = 1'b0;
        data_vld_i = 1'b0;
        check("R7 frozen", crc_o, model);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string s;
        void'($urandom(32'd4711));
        rst = 1'b1; init_i = 0; data_i = 0; data_vld_i = 0; rd_req_i = 0;
        model = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        check("R1 crc in reset", crc_o, 32'hFFFFFFFF);
        check("R1 vld in reset", 32'(rd_vld_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 crc after reset", crc_o, 32'hFFFFFFFF);

        // check value
        s = "123456789";
        do_init();
        for (int i = 0; i < s.len(); i++) send(s[i]);
        check("R5 register", crc_o, 32'h340BC6D9);
        model = 32'h340BC6D9;
        readout(1'b0);
        do_init();
        for (int i = 0; i < s.len(); i++) send(s[i]);
        rd_req_i = 1'b1;
        @(negedge clk); check("R5 byte0", 32'(rd_byte_o), 32'h26);
        @(negedge clk); check("R5 byte1", 32'(rd_byte_o), 32'h39);
        @(negedge clk); check("R5 byte2", 32'(rd_byte_o), 32'hF4);
        @(negedge clk); check("R5 byte3", 32'(rd_byte_o), 32'hCB);
        rd_req_i = 1'b0;
        @(negedge clk);

        // R4: idle with changing data
        for (int i = 0; i < 5; i++) begin
            data_i = 8'($urandom);
            @(negedge clk);
            check("R4 hold", crc_o, model);
        end

        // R2: init beats a valid byte
        send(8'h5A);
        init_i = 1'b1; data_i = 8'hA5; data_vld_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0; data_vld_i = 1'b0;
        model = 32'hFFFFFFFF;
        check("R2 init wins", crc_o, 32'hFFFFFFFF);

        // corner bytes
        send(8'h00); check("R3 zero byte", crc_o, model);
        send(8'hFF); check("R3 ones byte", crc_o, model);

        // R7 with junk, R8 continue afterwards
        send(8'h31);
        readout(1'b1);
        send(8'h32); check("R8 continue", crc_o, model);

        // random frames
        for (int f = 0; f < 30; f++) begin
            int len;
            do_init();
            len = 1 + int'($urandom % 20);
            for (int b = 0; b < len; b++) begin
                repeat ($urandom % 3) @(negedge clk);
                send(8'($urandom));
                check("R3 random", crc_o, model);
            end
            readout(bit'($urandom % 2));
            send(8'($urandom));
            check("R8 after readout", crc_o, model);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule